// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Control

This block is the hazard control that sits beside a five-stage integer pipeline with the stages fetch, decode/register read, execute, memory and write-back. It compares the source register numbers of the instruction in execute with the destination register numbers of the two older instructions that are still in flight. From that comparison it picks, for each of the two execute operands, whether the value comes from the register file, from the execute/memory pipeline register, or from the memory/write-back pipeline register. Operands are read only in decode and written only in write-back, so write-after-read ordering needs no logic here.

Bypassing cannot cover one case: a load whose result is needed by the very next instruction. When that instruction is in decode and the load is in execute, the block raises a stall that holds the program counter and the fetch/decode register, and a bubble that clears the control bits entering execute, for exactly one cycle. A store that needs the loaded value only as the data it writes does not stall. The loaded value reaches it in the memory stage through a registered select. The block also flags when the decode stage reads a register that write-back is writing in the same cycle, so the new value is returned. Register 0 is hard-wired to zero and is never bypassed.

Top module: `hz_fwd_unit`

## Requirements
- R1: When the execute/memory producer has write-enable set, a nonzero destination and a destination equal to an execute source, that operand select is 2'b01. This applies to operand A (source 1) and to operand B (source 2).
- R2: When only the memory/write-back producer matches under the same rule, the operand select is 2'b10. With no match the select is 2'b00 (register file).
- R3: When both producers match the same source, the execute/memory value (2'b01) wins.
- R4: A producer whose write-enable is low is never matched, whatever its destination.
- R5: Register 0 never matches. A zero source or a zero destination gives select 2'b00, no stall and no decode-stage bypass.
- R6: stall and bubble are both 1 in the same cycle exactly when a write-enabled load with a nonzero destination is in execute and the decode instruction uses, as flagged, a source equal to that destination. Otherwise both are 0.
- R7: A store in decode whose only match with the loading instruction in execute is its data source (source 2) does not stall. A match on its address source (source 1) does stall.
- R8: A store in execute whose data source matches a load in the memory stage gets operand B select 2'b00. In the following cycle st_data_fwd is 1, which steers the memory/write-back value into the store data. In every other case st_data_fwd is 0.
- R9: id_byp_a / id_byp_b is 1 when the write-back producer has write-enable set and a nonzero destination equal to decode source 1 / source 2.
- R10: While reset is asserted, and with all inputs idle, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| id_rs1 | input | REG_ADDR_W | Decode source 1 |
| id_rs2 | input | REG_ADDR_W | Decode source 2 |
| id_use_rs1 | input | 1 | Decode instruction reads source 1 |
| id_use_rs2 | input | 1 | Decode instruction reads source 2 |
| id_is_store | input | 1 | Decode instruction is a store |
| ex_rs1 | input | REG_ADDR_W | Execute source 1 |
| ex_rs2 | input | REG_ADDR_W | Execute source 2 (store data for stores) |
| ex_rd | input | REG_ADDR_W | Execute destination |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_is_store | input | 1 | Execute instruction is a store |
| mem_rd | input | REG_ADDR_W | Memory-stage destination |
| mem_wen | input | 1 | Memory-stage write-enable |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | REG_ADDR_W | Write-back destination |
| wb_wen | input | 1 | Write-back write-enable |
| fwd_a | output | 2 | Operand A select: 00 regfile, 01 EX/MEM, 10 MEM/WB |
| fwd_b | output | 2 | Operand B select, same encoding |
| st_data_fwd | output | 1 | Memory-stage store data taken from MEM/WB |
| id_byp_a | output | 1 | Decode source 1 takes the write-back value |
| id_byp_b | output | 1 | Decode source 2 takes the write-back value |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Clear control bits entering execute |

## Verification
The checker assumes that the pipeline registers advance in lock step. In particular, the load that sat in the memory stage is the write-back producer one cycle later, which lets the store-data select be checked against the write-back destination. Each directed task therefore moves the producer from the memory fields to the write-back fields at the next falling edge. It also clears the store-and-load condition before the select is sampled. All inputs change only on falling edges and are held steady across each rising edge.

// File: rtl/hz_pkg.sv
package hz_pkg;
   typedef enum logic [1:0] {
      FWD_RF    = 2'b00,
      FWD_EXMEM = 2'b01,
      FWD_MEMWB = 2'b10
   } fwd_sel_e;
endpackage

// File: rtl/hz_src_fwd.sv
module hz_src_fwd
   import hz_pkg::*;
#(
   parameter int AW = 5
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_wen,
   input  logic [AW-1:0] wb_rd,
   input  logic          wb_wen,
   input  logic          hold_off_mem,
   output fwd_sel_e      sel
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   logic hit_mem, hit_wb;

   assign hit_mem = mem_wen && (mem_rd == src) && (src != ZERO_REG);
   assign hit_wb  = wb_wen  && (wb_rd  == src) && (src != ZERO_REG);

   // The younger producer wins; a load value that is not ready yet is
   // replaced further down the pipe, so the register path is left in place.
   always_comb begin
      if (hit_mem)     sel = hold_off_mem ? FWD_RF : FWD_EXMEM;
      else if (hit_wb) sel = FWD_MEMWB;
      else             sel = FWD_RF;
   end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
   parameter int AW = 5
) (
   input  logic [AW-1:0] id_rs1,
   input  logic [AW-1:0] id_rs2,
   input  logic          id_use_rs1,
   input  logic          id_use_rs2,
   input  logic          id_is_store,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_wen,
   input  logic          ex_is_load,
   output logic          hazard
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   logic producer_ok, need_1, need_2;

   assign producer_ok = ex_is_load && ex_wen && (ex_rd != ZERO_REG);
   assign need_1      = id_use_rs1 && (id_rs1 == ex_rd);
   // store data is patched in the memory stage, so it never waits
   assign need_2      = id_use_rs2 && !id_is_store && (id_rs2 == ex_rd);
   assign hazard      = producer_ok && (need_1 || need_2);
endmodule

// File: rtl/hz_store_fwd.sv
module hz_store_fwd #(
   parameter int AW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ex_is_store,
   input  logic [AW-1:0] ex_rs2,
   input  logic [AW-1:0] mem_rd,
   input  logic          mem_wen,
   input  logic          mem_is_load,
   output logic          st_fwd
);
   localparam logic [AW-1:0] ZERO_REG = '0;

   logic st_fwd_d;

   assign st_fwd_d = ex_is_store && mem_is_load && mem_wen &&
                     (mem_rd == ex_rs2) && (ex_rs2 != ZERO_REG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_fwd <= 1'b0;
      else        st_fwd <= st_fwd_d;
   end
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
   import hz_pkg::*;
#(
   parameter int REG_ADDR_W    = 5,
   parameter bit RF_WRITE_FIRST = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [REG_ADDR_W-1:0] id_rs1,
   input  logic [REG_ADDR_W-1:0] id_rs2,
   input  logic                  id_use_rs1,
   input  logic                  id_use_rs2,
   input  logic                  id_is_store,
   input  logic [REG_ADDR_W-1:0] ex_rs1,
   input  logic [REG_ADDR_W-1:0] ex_rs2,
   input  logic [REG_ADDR_W-1:0] ex_rd,
   input  logic                  ex_wen,
   input  logic                  ex_is_load,
   input  logic                  ex_is_store,
   input  logic [REG_ADDR_W-1:0] mem_rd,
   input  logic                  mem_wen,
   input  logic                  mem_is_load,
   input  logic [REG_ADDR_W-1:0] wb_rd,
   input  logic                  wb_wen,
   output logic [1:0]            fwd_a,
   output logic [1:0]            fwd_b,
   output logic                  st_data_fwd,
   output logic                  id_byp_a,
   output logic                  id_byp_b,
   output logic                  stall,
   output logic                  bubble
);
   localparam int NUM_SRC = 2;
   localparam logic [REG_ADDR_W-1:0] ZERO_REG = '0;

   if (REG_ADDR_W < 1 || REG_ADDR_W > 8) begin : g_bad_width
      $error("hz_fwd_unit: REG_ADDR_W must lie in 1..8");
   end

   logic [REG_ADDR_W-1:0] ex_src  [NUM_SRC];
   logic                  hold_off[NUM_SRC];
   fwd_sel_e              sel     [NUM_SRC];
   logic                  hazard;

   assign ex_src[0]   = ex_rs1;
   assign ex_src[1]   = ex_rs2;
   assign hold_off[0] = 1'b0;
   assign hold_off[1] = ex_is_store && mem_is_load;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      hz_src_fwd #(.AW(REG_ADDR_W)) u_src (
         .src          (ex_src[i]),
         .mem_rd       (mem_rd),
         .mem_wen      (mem_wen),
         .wb_rd        (wb_rd),
         .wb_wen       (wb_wen),
         .hold_off_mem (hold_off[i]),
         .sel          (sel[i])
      );
   end

   assign fwd_a = sel[0];
   assign fwd_b = sel[1];

   hz_load_use #(.AW(REG_ADDR_W)) u_lu (
      .id_rs1      (id_rs1),
      .id_rs2      (id_rs2),
      .id_use_rs1  (id_use_rs1),
      .id_use_rs2  (id_use_rs2),
      .id_is_store (id_is_store),
      .ex_rd       (ex_rd),
      .ex_wen      (ex_wen),
      .ex_is_load  (ex_is_load),
      .hazard      (hazard)
   );

   assign stall  = hazard;
   assign bubble = hazard;

   hz_store_fwd #(.AW(REG_ADDR_W)) u_st (
      .clk         (clk),
      .rst_n       (rst_n),
      .ex_is_store (ex_is_store),
      .ex_rs2      (ex_rs2),
      .mem_rd      (mem_rd),
      .mem_wen     (mem_wen),
      .mem_is_load (mem_is_load),
      .st_fwd      (st_data_fwd)
   );

   if (RF_WRITE_FIRST) begin : g_rf_wf
      assign id_byp_a = 1'b0;
      assign id_byp_b = 1'b0;
   end else begin : g_rf_byp
      logic wb_live;
      assign wb_live  = wb_wen && (wb_rd != ZERO_REG);
      assign id_byp_a = wb_live && (wb_rd == id_rs1);
      assign id_byp_b = wb_live && (wb_rd == id_rs2);
   end
endmodule

// File: rtl/hz_fwd_chk.sv
module hz_fwd_chk #(
   parameter int AW = 5
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] ex_rs1,
   input logic [AW-1:0] ex_rs2,
   input logic [AW-1:0] ex_rd,
   input logic          ex_wen,
   input logic          ex_is_load,
   input logic [AW-1:0] mem_rd,
   input logic          mem_wen,
   input logic [AW-1:0] wb_rd,
   input logic          wb_wen,
   input logic [1:0]    fwd_a,
   input logic [1:0]    fwd_b,
   input logic          st_data_fwd,
   input logic          stall,
   input logic          bubble
);
   assert_exmem_a_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_a == 2'b01 |-> mem_wen && mem_rd == ex_rs1 && ex_rs1 != '0);
   assert_exmem_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_b == 2'b01 |-> mem_wen && mem_rd == ex_rs2 && ex_rs2 != '0);
   assert_memwb_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_a == 2'b10 |-> wb_wen && wb_rd == ex_rs1 && ex_rs1 != '0);
   assert_prio_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wen && mem_rd == ex_rs1 && ex_rs1 != '0) |-> fwd_a == 2'b01);
   assert_zero_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ex_rs1 == '0 |-> fwd_a == 2'b00);
   assert_stall_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> ex_is_load && ex_wen && ex_rd != '0);
   assert_stall_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      stall == bubble);
   assert_store_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
      st_data_fwd |-> wb_wen && wb_rd != '0);
endmodule

bind hz_fwd_unit hz_fwd_chk #(.AW(REG_ADDR_W)) u_chk (
   .clk (clk), .rst_n (rst_n),
   .ex_rs1 (ex_rs1), .ex_rs2 (ex_rs2), .ex_rd (ex_rd),
   .ex_wen (ex_wen), .ex_is_load (ex_is_load),
   .mem_rd (mem_rd), .mem_wen (mem_wen),
   .wb_rd (wb_rd), .wb_wen (wb_wen),
   .fwd_a (fwd_a), .fwd_b (fwd_b), .st_data_fwd (st_data_fwd),
   .stall (stall), .bubble (bubble)
);

// File: tb/sim_hz_fwd_unit.sv
module sim_hz_fwd_unit;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
   logic id_use_rs1, id_use_rs2, id_is_store, ex_wen, ex_is_load, ex_is_store;
   logic mem_wen, mem_is_load, wb_wen;
   logic [1:0] fwd_a, fwd_b;
   logic st_data_fwd, id_byp_a, id_byp_b, stall, bubble;
   int n_chk = 0, n_err = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hz_fwd_unit #(.REG_ADDR_W(AW)) u0 (.*);

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic idle();
      id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 0; id_use_rs2 = 0; id_is_store = 0;
      ex_rs1 = '0; ex_rs2 = '0; ex_rd = '0; ex_wen = 0; ex_is_load = 0; ex_is_store = 0;
      mem_rd = '0; mem_wen = 0; mem_is_load = 0; wb_rd = '0; wb_wen = 0;
   endtask

   task automatic step();
      @(negedge clk);
      idle();
   endtask

   task automatic t_reset();
      idle();
      #(CLK_PERIOD*2 + 1);
      check("R10 fwd_a", fwd_a, 0); check("R10 fwd_b", fwd_b, 0);
      check("R10 st", st_data_fwd, 0); check("R10 stall", stall, 0);
      check("R10 byp", {id_byp_a, id_byp_b}, 0);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_back_to_back();
      step(); ex_rs1 = 3; ex_rs2 = 4; mem_rd = 3; mem_wen = 1; #1;
      check("R1 a", fwd_a, 1); check("R1 b none", fwd_b, 0);
      step(); ex_rs1 = 2; ex_rs2 = 3; mem_rd = 3; mem_wen = 1; #1;
      check("R1 b", fwd_b, 1); check("R2 a none", fwd_a, 0);
   endtask

   task automatic t_distance2();
      step(); ex_rs1 = 4; ex_rs2 = 4; wb_rd = 4; wb_wen = 1; mem_rd = 9; mem_wen = 1; #1;
      check("R2 a", fwd_a, 2); check("R2 b", fwd_b, 2);
   endtask

   task automatic t_priority();
      step(); ex_rs1 = 5; ex_rs2 = 5; mem_rd = 5; mem_wen = 1; wb_rd = 5; wb_wen = 1; #1;
      check("R3 a", fwd_a, 1); check("R3 b", fwd_b, 1);
   endtask

   task automatic t_wen();
      step(); ex_rs1 = 6; ex_rs2 = 6; mem_rd = 6; wb_rd = 6; #1;
      check("R4 a", fwd_a, 0); check("R4 b", fwd_b, 0);
      step(); ex_rs1 = 6; mem_rd = 6; wb_rd = 6; wb_wen = 1; #1;
      check("R4 wb only", fwd_a, 2);
      step(); ex_is_load = 1; ex_rd = 7; id_rs1 = 7; id_use_rs1 = 1; #1;
      check("R4 load no wen", stall, 0);
   endtask

   task automatic t_r0();
      step(); mem_wen = 1; wb_wen = 1; ex_rs1 = 0; ex_rs2 = 0; #1;
      check("R5 a", fwd_a, 0); check("R5 b", fwd_b, 0);
      step(); ex_is_load = 1; ex_wen = 1; ex_rd = 0; id_use_rs1 = 1; id_use_rs2 = 1; #1;
      check("R5 stall", stall, 0);
      step(); wb_wen = 1; #1;
      check("R5 byp", {id_byp_a, id_byp_b}, 0);
   endtask

   task automatic t_load_use();
      step(); ex_is_load = 1; ex_wen = 1; ex_rd = 7; id_rs1 = 7; id_use_rs1 = 1; #1;
      check("R6 stall rs1", stall, 1); check("R6 bubble", bubble, 1);
      step(); ex_is_load = 1; ex_wen = 1; ex_rd = 7; id_rs2 = 7; id_use_rs2 = 1; #1;
      check("R6 stall rs2", stall, 1);
      step(); ex_is_load = 1; ex_wen = 1; ex_rd = 7; id_rs1 = 7; #1;
      check("R6 unused src", stall, 0);
      step(); ex_is_load = 1; ex_wen = 1; ex_rd = 7; id_rs1 = 8; id_use_rs1 = 1; #1;
      check("R6 other reg", {stall, bubble}, 0);
      step(); ex_wen = 1; ex_rd = 7; id_rs1 = 7; id_use_rs1 = 1; #1;
      check("R6 not load", stall, 0);
   endtask

   task automatic t_load_store();
      step(); ex_is_load = 1; ex_wen = 1; ex_rd = 8;
      id_is_store = 1; id_rs1 = 2; id_use_rs1 = 1; id_rs2 = 8; id_use_rs2 = 1; #1;
      check("R7 data only", stall, 0);
      step(); ex_is_load = 1; ex_wen = 1; ex_rd = 8;
      id_is_store = 1; id_rs1 = 8; id_use_rs1 = 1; id_rs2 = 3; id_use_rs2 = 1; #1;
      check("R7 address", stall, 1);
      step(); ex_is_store = 1; ex_rs1 = 2; ex_rs2 = 8; mem_rd = 8; mem_wen = 1; mem_is_load = 1; #1;
      check("R8 fwd_b held", fwd_b, 0); check("R8 st before", st_data_fwd, 0);
      step(); wb_rd = 8; wb_wen = 1; #1;
      check("R8 st next", st_data_fwd, 1);
      step(); #1;
      check("R8 st clears", st_data_fwd, 0);
      step(); ex_is_store = 1; ex_rs2 = 8; mem_rd = 8; mem_wen = 1; #1;
      check("R8 alu producer", fwd_b, 1);
      step(); wb_rd = 8; wb_wen = 1; #1;
      check("R8 no st for alu", st_data_fwd, 0);
   endtask

   task automatic t_wb_bypass();
      step(); wb_rd = 9; wb_wen = 1; id_rs1 = 9; id_rs2 = 1; #1;
      check("R9 a", id_byp_a, 1); check("R9 b none", id_byp_b, 0);
      step(); wb_rd = 9; wb_wen = 1; id_rs2 = 9; #1;
      check("R9 b", id_byp_b, 1);
      step(); wb_rd = 9; id_rs1 = 9; #1;
      check("R9 no wen", id_byp_a, 0);
   endtask

   initial begin
      t_reset();
      t_back_to_back();
      t_distance2();
      t_priority();
      t_wen();
      t_r0();
      t_load_use();
      t_load_store();
      t_wb_bypass();
      step();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      #(CLK_PERIOD*200000);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog: actual 0 expected 1");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end
endmodule